// File: doc/BRIEF.md
# Flash Erase and Program Sequencer

This block sits behind a serial command front-end and carries out the three write-type operations of a small flash store: erasing one sector, erasing the whole array, and programming one byte. Each operation runs for a fixed number of clock cycles. This count stands in for the internal write time, so the sequencer can be timed like a real device in a system model. A behavioural byte array holds the contents. A combinational read port lets the front-end serve read traffic.

A request is taken only while the write-allow input is high and no operation is running. Requests that fail either condition are dropped without any trace. While an operation runs, the ready bit is low. An erase clears its area one byte per cycle in ascending order and then waits out the rest of its time. A program merges its data into the byte on the last cycle. An active-low asynchronous reset stops whatever is running. The area already erased stays erased, and a pending program is not applied.

Top module: `flash_seq`

## Requirements
- R1: After reset is released, `ready_o` is 1 and no operation is in progress.
- R2: `req_op_i` = 2'b01 (sector erase) sets to FFh every byte whose upper address bits `[ADDR_W-1:SECT_OFS]` match those of `req_addr_i`. The low `SECT_OFS` address bits are ignored, and bytes outside that sector keep their values.
- R3: `req_op_i` = 2'b10 (chip erase) sets every byte of the array to FFh.
- R4: `req_op_i` = 2'b11 (byte program) stores the bitwise AND of the old byte and `req_data_i`. Bits can only go from 1 to 0.
- R5: `ready_o` falls in the cycle after acceptance and stays low for exactly `PROG_CYC` cycles for a program. For a sector erase it stays low for max(`SECT_CYC`, sector size) cycles, and for a chip erase for max(`CHIP_CYC`, array size) cycles.
- R6: A request made while `wr_allow_i` is 0 is dropped. `ready_o` stays 1 and the array is unchanged.
- R7: A request made while `ready_o` is 0 is ignored. It changes neither the array nor the length of the running operation.
- R8: A low `rst_n` at once returns `ready_o` to 1. An erase writes one byte per cycle in ascending address order, starting at the first clock edge after acceptance. When it is aborted, the bytes it reached are FFh and the others keep their values. An aborted program leaves its byte unchanged.
- R9: A request with `req_op_i` = 2'b00 has no effect.
- R10: `rd_data_o` shows the stored byte at `rd_addr_i` without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously; aborts any operation |
| req_valid_i | input | 1 | Request strobe, sampled on the rising edge |
| req_op_i | input | 2 | Operation code: 00 none, 01 sector erase, 10 chip erase, 11 program |
| req_addr_i | input | ADDR_W | Byte address (upper bits select the sector) |
| req_data_i | input | 8 | Program data |
| wr_allow_i | input | 1 | Write protection: 1 allows erase and program |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Stored byte at `rd_addr_i` |
| ready_o | output | 1 | 1 when idle, 0 while an operation runs |

## Verification
The bench reprograms a byte that is not erased. A design that overwrote the byte instead of ANDing would show the new data rather than the merged value. It erases with nonzero low address bits, so a design that used those bits would erase the wrong range or run off the sector. It sends a request in the middle of a program; a design that latched that request would erase a sector or stretch the busy time. It also resets in the middle of an erase and of a program. After those aborts the bench compares the whole array against its own model, so an erase order other than ascending, a lost partial erase, or a program applied early would each show up as wrong bytes.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_SECT = 2'b01,
    OP_CHIP = 2'b10,
    OP_PROG = 2'b11
  } fs_op_e;

  function automatic int fs_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fs_ctrl.sv
module fs_ctrl
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SECT_OFS = 5,
  parameter int PROG_CYC = 20,
  parameter int SECT_CYC = 48,
  parameter int CHIP_CYC = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  fs_op_e            req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_data_i,
  input  logic              wr_allow_i,
  output logic              busy_o,
  output logic              start_o,
  output logic              finish_o,
  output fs_op_e            op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        data_o
);

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int SECT_BYTES = 1 << SECT_OFS;
  localparam int SECT_EFF   = fs_max(SECT_CYC, SECT_BYTES);
  localparam int CHIP_EFF   = fs_max(CHIP_CYC, DEPTH);
  localparam int MAX_LEN    = fs_max(fs_max(PROG_CYC, SECT_EFF), CHIP_EFF);
  localparam int CNT_W      = $clog2(MAX_LEN + 1);

  typedef enum logic {ST_IDLE, ST_BUSY} st_e;

  st_e               state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  len_m1;
  fs_op_e            op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              accept;

  assign accept = (state_q == ST_IDLE) && req_valid_i && wr_allow_i &&
                  (req_op_i != OP_NONE);

  always_comb begin
    case (req_op_i)
      OP_SECT: len_m1 = CNT_W'(SECT_EFF - 1);
      OP_CHIP: len_m1 = CNT_W'(CHIP_EFF - 1);
      default: len_m1 = CNT_W'(PROG_CYC - 1);
    endcase
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (accept) begin
      state_d = ST_BUSY;
      cnt_d   = len_m1;
    end else if (state_q == ST_BUSY) begin
      if (cnt_q == '0) state_d = ST_IDLE;
      else             cnt_d   = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // request latch, clock-enabled by acceptance, no reset on datapath
  always_ff @(posedge clk) begin
    if (accept) begin
      op_q   <= req_op_i;
      addr_q <= req_addr_i;
      data_q <= req_data_i;
    end
  end

  assign busy_o   = (state_q == ST_BUSY);
  assign start_o  = accept;
  assign finish_o = (state_q == ST_BUSY) && (cnt_q == '0);
  assign op_o     = op_q;
  assign addr_o   = addr_q;
  assign data_o   = data_q;

  assert_accept_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> busy_o);
  assert_hold_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !finish_o |=> busy_o);
  assert_wp_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_valid_i && !wr_allow_i) |=> !busy_o);
  assert_busy_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !finish_o) |=> ($stable(addr_o) && $stable(op_o) && $stable(data_o)));
  assert_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_op_i == OP_NONE) |=> !busy_o);

endmodule

// File: rtl/fs_walker.sv
module fs_walker
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SECT_OFS = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  fs_op_e                     op_i,
  input  logic [ADDR_W-SECT_OFS-1:0] sect_i,
  output logic                       we_o,
  output logic [ADDR_W-1:0]          waddr_o
);

  localparam int SIDX_W = ADDR_W - SECT_OFS;

  logic              active_q, active_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] end_q, end_d;
  logic              erase_start;

  assign erase_start = start_i && (op_i == OP_SECT || op_i == OP_CHIP);

  always_comb begin
    active_d = active_q;
    ptr_d    = ptr_q;
    end_d    = end_q;
    if (erase_start) begin
      active_d = 1'b1;
      if (op_i == OP_CHIP) begin
        ptr_d = '0;
        end_d = '1;
      end else begin
        ptr_d = {sect_i, {SECT_OFS{1'b0}}};
        end_d = {sect_i, {SECT_OFS{1'b1}}};
      end
    end else if (active_q) begin
      if (ptr_q == end_q) active_d = 1'b0;
      else                ptr_d    = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ptr_q    <= '0;
      end_q    <= '0;
    end else begin
      active_q <= active_d;
      ptr_q    <= ptr_d;
      end_q    <= end_d;
    end
  end

  assign we_o    = active_q;
  assign waddr_o = ptr_q;

  // R8: ascending, one byte per cycle
  assert_walk_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_o && !start_i) |=> (!we_o || waddr_o == $past(waddr_o) + 1'b1));
  assert_walk_sector_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_o && !start_i) |=> (!we_o || waddr_o[ADDR_W-1:SECT_OFS] == $past(waddr_o[ADDR_W-1:SECT_OFS])
                              || $past(end_q) == {SIDX_W+SECT_OFS{1'b1}}));

endmodule

// File: rtl/fs_array.sv
module fs_array #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic              and_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];
  logic [7:0] merged;

  assign merged = and_i ? (mem[waddr_i] & wdata_i) : wdata_i;

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= merged;
  end

  assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SECT_OFS = 5,
  parameter int PROG_CYC = 20,
  parameter int SECT_CYC = 48,
  parameter int CHIP_CYC = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_data_i,
  input  logic              wr_allow_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              ready_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              busy, start, finish;
  fs_op_e            op_l;
  logic [ADDR_W-1:0] addr_l;
  logic [7:0]        data_l;
  logic              walk_we;
  logic [ADDR_W-1:0] walk_addr;
  logic              prog_we;
  logic              arr_we, arr_and;
  logic [ADDR_W-1:0] arr_waddr;
  logic [7:0]        arr_wdata;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fs_ctrl #(
    .ADDR_W(ADDR_W), .SECT_OFS(SECT_OFS), .PROG_CYC(PROG_CYC),
    .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid_i(req_valid_i),
    .req_op_i   (fs_op_e'(req_op_i)),
    .req_addr_i (req_addr_i),
    .req_data_i (req_data_i),
    .wr_allow_i (wr_allow_i),
    .busy_o     (busy),
    .start_o    (start),
    .finish_o   (finish),
    .op_o       (op_l),
    .addr_o     (addr_l),
    .data_o     (data_l)
  );

  fs_walker #(.ADDR_W(ADDR_W), .SECT_OFS(SECT_OFS)) u_walker (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start_i(start),
    .op_i   (fs_op_e'(req_op_i)),
    .sect_i (req_addr_i[ADDR_W-1:SECT_OFS]),
    .we_o   (walk_we),
    .waddr_o(walk_addr)
  );

  assign prog_we   = finish && (op_l == OP_PROG);
  assign arr_we    = walk_we || prog_we;
  assign arr_and   = !walk_we;
  assign arr_waddr = walk_we ? walk_addr : addr_l;
  assign arr_wdata = walk_we ? 8'hFF : data_l;

  fs_array #(.ADDR_W(ADDR_W)) u_array (
    .clk    (clk),
    .we_i   (arr_we),
    .and_i  (arr_and),
    .waddr_i(arr_waddr),
    .wdata_i(arr_wdata),
    .raddr_i(rd_addr_i),
    .rdata_o(rd_data_o)
  );

  assign ready_o = !busy;

  assert_no_collide_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(walk_we && prog_we));
  assert_walk_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    walk_we |-> busy);

endmodule

// File: tb/flash_seq_tb.sv
`timescale 1ns/1ps
module flash_seq_tb;

  localparam int ADDR_W = 8;
  localparam int SOFS   = 5;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PROG_N = 20;
  localparam int SECT_N = 48;
  localparam int CHIP_N = 300;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [1:0]        req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [7:0]        req_data;
  logic              wr_allow;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;
  logic              ready;

  always #2.5 clk = ~clk;

  flash_seq #(.ADDR_W(ADDR_W), .SECT_OFS(SOFS), .PROG_CYC(PROG_N),
              .SECT_CYC(SECT_N), .CHIP_CYC(CHIP_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_data_i(req_data), .wr_allow_i(wr_allow),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .ready_o(ready)
  );

  typedef struct {
    int         addr;
    logic [7:0] exp;
    int         rq;
  } sb_item_t;

  sb_item_t   sb_q[$];
  logic [7:0] model [DEPTH];
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 0;

  task automatic chk(input bit ok, input int rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // scoreboard monitor: pops expected bytes, reads them through the port (R10)
  initial begin
    rd_addr = '0;
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        rd_addr = ADDR_W'(it.addr);
        #1;
        chk(rd_data == it.exp, it.rq, rd_data, it.exp);
      end
    end
  end

  task automatic expect_all(input int rq);
    for (int a = 0; a < DEPTH; a++) begin
      sb_item_t it;
      it.addr = a; it.exp = model[a]; it.rq = rq;
      sb_q.push_back(it);
    end
    wait (sb_q.size() == 0);
    #2;
    @(negedge clk);
  endtask

  task automatic drive(input logic [1:0] op, input int addr, input logic [7:0] d,
                       input bit allow);
    req_valid = 1'b1; req_op = op; req_addr = ADDR_W'(addr);
    req_data = d; wr_allow = allow;
  endtask

  // issue one request, count cycles with ready low; optional intrusion mid-run
  task automatic run_op(input logic [1:0] op, input int addr, input logic [7:0] d,
                        input bit allow, input int rq, input int exp_len,
                        input int intrude_at);
    int cnt;
    @(negedge clk);
    drive(op, addr, d, allow);
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 0;
    while (!ready && cnt < 5000) begin
      cnt++;
      if (cnt == intrude_at) drive(2'b01, 0, 8'h00, 1'b1);
      else                   req_valid = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(cnt == exp_len, rq, cnt, exp_len);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int base;
    req_valid = 1'b0; req_op = 2'b00; req_addr = '0; req_data = '0; wr_allow = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, 1, ready, 1);                       // R1

    // R3 chip erase, busy max(CHIP_N, DEPTH) (R5)
    run_op(2'b10, 8'h33, 8'h00, 1'b1, 3, CHIP_N, 0);
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    expect_all(3);

    // R4 program, merged by AND on a second program
    run_op(2'b11, 8'h05, 8'hA5, 1'b1, 5, PROG_N, 0); model[8'h05] &= 8'hA5;
    run_op(2'b11, 8'h05, 8'h0F, 1'b1, 4, PROG_N, 0); model[8'h05] &= 8'h0F;
    run_op(2'b11, 8'h40, 8'h3C, 1'b1, 4, PROG_N, 0); model[8'h40] &= 8'h3C;
    run_op(2'b11, 8'h47, 8'h81, 1'b1, 4, PROG_N, 0); model[8'h47] &= 8'h81;
    run_op(2'b11, 8'h60, 8'h12, 1'b1, 4, PROG_N, 0); model[8'h60] &= 8'h12;
    run_op(2'b11, 8'h7F, 8'h77, 1'b1, 4, PROG_N, 0); model[8'h7F] &= 8'h77;
    expect_all(4);

    // R6 write-allow low: dropped
    run_op(2'b01, 8'h40, 8'h00, 1'b0, 6, 0, 0);
    run_op(2'b11, 8'h05, 8'h00, 1'b0, 6, 0, 0);
    expect_all(6);

    // R9 no-op code
    run_op(2'b00, 8'h05, 8'h00, 1'b1, 9, 0, 0);
    expect_all(9);

    // R2 sector erase with nonzero low address bits
    run_op(2'b01, 8'h6B, 8'h00, 1'b1, 2, SECT_N, 0);
    for (int a = 8'h60; a < 8'h80; a++) model[a] = 8'hFF;
    expect_all(2);

    // R7 request during busy is ignored
    run_op(2'b11, 8'h10, 8'h55, 1'b1, 7, PROG_N, 5); model[8'h10] &= 8'h55;
    expect_all(7);

    // R8 abort a sector erase after 10 bytes
    run_op(2'b11, 8'h49, 8'h11, 1'b1, 4, PROG_N, 0); model[8'h49] &= 8'h11;
    run_op(2'b11, 8'h4A, 8'h22, 1'b1, 4, PROG_N, 0); model[8'h4A] &= 8'h22;
    run_op(2'b11, 8'h54, 8'h33, 1'b1, 4, PROG_N, 0); model[8'h54] &= 8'h33;
    @(negedge clk);
    drive(2'b01, 8'h40, 8'h00, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(ready == 1'b0, 5, ready, 0);                       // R5 busy started
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(ready == 1'b1, 8, ready, 1);                       // R8 abort
    base = 8'h40;
    for (int k = 0; k < 10; k++) model[base + k] = 8'hFF;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, 1, ready, 1);                       // R1
    expect_all(8);

    // R8 abort a program: byte untouched
    @(negedge clk);
    drive(2'b11, 8'h4A, 8'h00, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(ready == 1'b1, 8, ready, 1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_all(8);

    // normal operation resumes after abort (R4, R5)
    run_op(2'b11, 8'h4A, 8'h02, 1'b1, 5, PROG_N, 0); model[8'h4A] &= 8'h02;
    do_reset();
    expect_all(10);                                        // R10 read port

    done = 1;
    summary();
  end

endmodule